// File: doc/BRIEF.md
# Multi-String Phase-Aligned PWM Dimmer

This block produces the on/off dimming waveforms for sixteen LED strings. A frame-rate strobe starts each dimming period, and a grayscale tick enable times everything inside the period. Every string has its own on-time and its own phase delay, both counted in ticks. A single anchor mode is shared by all strings. It chooses the pulse edge that the phase delay fixes: the leading edge, the centre, or the trailing edge. For the trailing edge the delay can be counted forward from the frame start or backward from the next strobe. A global gain scales every on-time.

A host writes configuration through a simple parallel write port into a shadow set. The shadow set is copied to the active set on the next frame strobe, so a frame never mixes old and new values. The block measures the frame length in ticks from the two most recent strobes and clips every pulse to that length. In bypass mode the generated waveforms are replaced. Each string then receives an external PWM input, delayed by its share of that input's measured period, which staggers the turn-on times of the strings.

Top module: `phased_dimmer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `str_out` is all zeros. After reset all active and shadow values are zero, the mode is 0 and bypass is off.
- R2: A write (`wr_en` high for one cycle) decodes `wr_addr` as follows:
  - 0..15: on-time of string `wr_addr`
  - 16..31: phase delay of string `wr_addr`−16
  - 32: 12-bit gain
  - 33: anchor mode, taken from `wr_data[1:0]` (0 leading, 1 centre, 2 trailing-forward, 3 trailing-backward)
  - 34: bypass enable, taken from `wr_data[0]`
  - Every other address is ignored.
- R3: Writes change only the shadow set. The active set is loaded from the shadow set on the clock edge at which `frame_stb` is high, so outputs within a frame never reflect a write made during that frame.
- R4: The position is the count of `gsc_tick` pulses since the last strobe. The frame length L is the position reached just before a strobe, latched from the second strobe after reset onward; it is 0 until then. In generated mode a string is high only while position < L. `str_out` follows a change of position or of the active set one clock later.
- R5: The effective width is W = floor(on_time × gain / 4096). When W = 0 the string stays low for the whole frame.
- R6: Mode 0: the string is high for positions D ≤ p < D+W, where D is the phase delay.
- R7: Mode 1: the string is high for positions D−floor(W/2) ≤ p < D−floor(W/2)+W. The pulse centre therefore lies at D or D+½ tick.
- R8: Mode 2: the falling edge sits at D counted from the frame start and the pulse covers D−W ≤ p < D. If D−W is negative, the pulse also covers p ≥ L+(D−W), wrapping over the frame boundary.
- R9: Mode 3: the falling edge sits at L−D and the pulse covers L−D−W ≤ p < L−D.
- R10: With bypass active, let P be the clock count between the last two rising edges of `pwm_in`. String n repeats `pwm_in` delayed by floor(n·P/16) clocks more than string 0.
- R11: The bypass enable takes effect at a strobe like the other fields. While it is active, all strings carry the delayed `pwm_in`. Once it is cleared at a later strobe, the generated waveforms return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle frame-start strobe |
| gsc_tick | input | 1 | Grayscale tick enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 12 | Register write data |
| pwm_in | input | 1 | External PWM source for bypass |
| str_out | output | 16 | String on/off outputs |

## Verification
Four behaviours are checked on every cycle: the outputs are quiet after reset; in generated mode `str_out` holds still through every cycle without a tick or strobe; nothing is lit at or past the measured frame length; and a string whose active width is zero stays dark. The exact edge placement of each anchor mode, the wrap of the trailing-forward mode, the gain truncation, the shadow-to-active hand-over at frame boundaries and the per-string stagger in bypass can only be shown by the bench's frames. Those frames are compared position by position against a model built from the requirements.

// File: rtl/pd_pkg.sv
package pd_pkg;

    localparam int PD_CNT_W = 12;

    typedef logic [PD_CNT_W-1:0] pd_cnt_t;

    typedef enum logic [1:0] {
        ANC_LEAD       = 2'd0,
        ANC_MID        = 2'd1,
        ANC_TRAIL_FWD  = 2'd2,
        ANC_TRAIL_BACK = 2'd3
    } pd_anchor_e;

    typedef struct packed {
        pd_cnt_t on_t;
        pd_cnt_t dly;
    } pd_str_cfg_t;

    typedef struct packed {
        pd_cnt_t    gain;
        pd_anchor_e anchor;
        logic       bypass;
    } pd_glob_t;

    // effective width = on_time * gain / 2^PD_CNT_W, truncated
    function automatic pd_cnt_t pd_scale(input pd_cnt_t on_t, input pd_cnt_t gain);
        logic [2*PD_CNT_W-1:0] prod;
        prod = {{PD_CNT_W{1'b0}}, on_t} * {{PD_CNT_W{1'b0}}, gain};
        return pd_cnt_t'(prod >> PD_CNT_W);
    endfunction

endpackage

// File: rtl/pd_regs.sv
module pd_regs
    import pd_pkg::*;
#(
    parameter int NUM_STR = 16,
    parameter int ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  pd_cnt_t           wr_data,
    input  logic              frame_stb,
    output pd_cnt_t           act_w   [NUM_STR],
    output pd_cnt_t           act_dly [NUM_STR],
    output pd_anchor_e        act_mode,
    output logic              act_byp
);

    localparam int GAIN_ADDR = 2 * NUM_STR;
    localparam int MODE_ADDR = GAIN_ADDR + 1;
    localparam int BYP_ADDR  = GAIN_ADDR + 2;

    pd_str_cfg_t sh_str [NUM_STR];
    pd_glob_t    sh_glob;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_glob  <= '{gain: '0, anchor: ANC_LEAD, bypass: 1'b0};
            act_mode <= ANC_LEAD;
            act_byp  <= 1'b0;
        end else begin
            if (wr_en && wr_addr == ADDR_W'(GAIN_ADDR)) sh_glob.gain   <= wr_data;
            if (wr_en && wr_addr == ADDR_W'(MODE_ADDR)) sh_glob.anchor <= pd_anchor_e'(wr_data[1:0]);
            if (wr_en && wr_addr == ADDR_W'(BYP_ADDR))  sh_glob.bypass <= wr_data[0];
            if (frame_stb) begin
                act_mode <= sh_glob.anchor;
                act_byp  <= sh_glob.bypass;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_STR; i++) begin
                sh_str[i]  <= '0;
                act_w[i]   <= '0;
                act_dly[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_STR; i++) begin
                if (wr_en && wr_addr == ADDR_W'(i))           sh_str[i].on_t <= wr_data;
                if (wr_en && wr_addr == ADDR_W'(NUM_STR + i)) sh_str[i].dly  <= wr_data;
                if (frame_stb) begin
                    act_w[i]   <= pd_scale(sh_str[i].on_t, sh_glob.gain);
                    act_dly[i] <= sh_str[i].dly;
                end
            end
        end
    end

endmodule

// File: rtl/pd_frame_timer.sv
module pd_frame_timer #(
    parameter int POS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_stb,
    input  logic             gsc_tick,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] flen
);

    logic seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= '0;
            flen <= '0;
            seen <= 1'b0;
        end else if (frame_stb) begin
            pos  <= '0;
            seen <= 1'b1;
            if (seen) flen <= pos;
        end else if (gsc_tick && pos != '1) begin
            pos <= pos + 1'b1;
        end
    end

endmodule

// File: rtl/pd_window.sv
module pd_window
    import pd_pkg::*;
#(
    parameter int POS_W = 16
) (
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] flen,
    input  pd_cnt_t          width,
    input  pd_cnt_t          dly,
    input  pd_anchor_e       anchor,
    output logic             lit
);

    localparam int SW  = POS_W + 2;
    localparam int PXW = SW - POS_W;
    localparam int CXW = SW - PD_CNT_W;

    typedef logic signed [SW-1:0] s_t;

    s_t   p_s, l_s, w_s, d_s, lo, hi;
    logic wrap;

    always_comb begin
        p_s  = $signed({{PXW{1'b0}}, pos});
        l_s  = $signed({{PXW{1'b0}}, flen});
        w_s  = $signed({{CXW{1'b0}}, width});
        d_s  = $signed({{CXW{1'b0}}, dly});
        lo   = d_s;
        hi   = d_s + w_s;
        wrap = 1'b0;
        case (anchor)
            ANC_LEAD: begin
                lo = d_s;
                hi = d_s + w_s;
            end
            ANC_MID: begin
                lo = d_s - (w_s >>> 1);
                hi = lo + w_s;
            end
            ANC_TRAIL_FWD: begin
                hi   = d_s;
                lo   = d_s - w_s;
                wrap = lo[SW-1];
            end
            ANC_TRAIL_BACK: begin
                hi = l_s - d_s;
                lo = hi - w_s;
            end
            default: ;
        endcase
        lit = (p_s < l_s) && ((p_s >= lo && p_s < hi) || (wrap && p_s >= l_s + lo));
    end

endmodule

// File: rtl/pd_stagger.sv
module pd_stagger #(
    parameter int NUM_STR = 16,
    parameter int AGE_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwm_in,
    output logic [NUM_STR-1:0] lane
);

    localparam int LG = $clog2(NUM_STR);
    localparam int PW = AGE_W + LG;

    logic             pwm_q;
    logic [AGE_W-1:0] age_r, age_f, per;
    logic             rise, fall;
    logic [NUM_STR-1:0] set_v, clr_v;

    assign rise = pwm_in & ~pwm_q;
    assign fall = ~pwm_in & pwm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q <= 1'b0;
            age_r <= '1;
            age_f <= '1;
            per   <= '0;
        end else begin
            pwm_q <= pwm_in;
            if (rise) begin
                age_r <= '0;
                if (age_r != '1) per <= age_r + 1'b1;
            end else if (age_r != '1) begin
                age_r <= age_r + 1'b1;
            end
            if (fall)              age_f <= '0;
            else if (age_f != '1)  age_f <= age_f + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_STR; g++) begin : g_lane
        logic [PW-1:0]    prod;
        logic [AGE_W-1:0] off;
        assign prod     = {{LG{1'b0}}, per} * PW'(g);
        assign off      = AGE_W'(prod >> LG);
        assign set_v[g] = (age_r == off);
        assign clr_v[g] = (age_f == off);
    end

    always_ff @(posedge clk) begin
        if (rst) lane <= '0;
        else     lane <= (lane & ~clr_v) | set_v;
    end

endmodule

// File: rtl/phased_dimmer.sv
module phased_dimmer
    import pd_pkg::*;
#(
    parameter int NUM_STR = 16,
    parameter int POS_W   = 16,
    parameter int ADDR_W  = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_stb,
    input  logic                gsc_tick,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [PD_CNT_W-1:0] wr_data,
    input  logic                pwm_in,
    output logic [NUM_STR-1:0]  str_out
);

    pd_cnt_t            act_w   [NUM_STR];
    pd_cnt_t            act_dly [NUM_STR];
    pd_anchor_e         act_mode;
    logic               act_byp;
    logic [POS_W-1:0]   pos, flen;
    logic [NUM_STR-1:0] gen_lit, lane;

    pd_regs #(.NUM_STR(NUM_STR), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_stb(frame_stb), .act_w(act_w), .act_dly(act_dly),
        .act_mode(act_mode), .act_byp(act_byp)
    );

    pd_frame_timer #(.POS_W(POS_W)) u_timer (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .gsc_tick(gsc_tick),
        .pos(pos), .flen(flen)
    );

    for (genvar g = 0; g < NUM_STR; g++) begin : g_win
        pd_window #(.POS_W(POS_W)) u_win (
            .pos(pos), .flen(flen), .width(act_w[g]), .dly(act_dly[g]),
            .anchor(act_mode), .lit(gen_lit[g])
        );
    end

    pd_stagger #(.NUM_STR(NUM_STR), .AGE_W(POS_W)) u_stagger (
        .clk(clk), .rst(rst), .pwm_in(pwm_in), .lane(lane)
    );

    always_ff @(posedge clk) begin
        if (rst) str_out <= '0;
        else     str_out <= act_byp ? lane : gen_lit;
    end

endmodule

// File: rtl/pd_checker.sv
module pd_checker
    import pd_pkg::*;
#(
    parameter int NUM_STR = 16,
    parameter int POS_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               frame_stb,
    input logic               gsc_tick,
    input logic [NUM_STR-1:0] str_out,
    input logic               act_byp,
    input logic [POS_W-1:0]   pos,
    input logic [POS_W-1:0]   flen,
    input pd_cnt_t            act_w [NUM_STR]
);

    // R1: outputs quiet on leaving reset
    a_r1_reset_low: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> str_out == '0);

    // R4: generated outputs move only after a tick or strobe
    a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        (!act_byp && !$past(gsc_tick) && !$past(frame_stb)) |=> $stable(str_out));

    // R4: nothing lit at or beyond the measured frame length
    a_r4_clip_past_frame: assert property (@(posedge clk) disable iff (rst)
        (!act_byp && pos >= flen) |=> str_out == '0);

    // R5: zero effective width keeps the string dark
    for (genvar g = 0; g < NUM_STR; g++) begin : g_zw
        a_r5_zero_width_low: assert property (@(posedge clk) disable iff (rst)
            (!act_byp && act_w[g] == '0) |=> !str_out[g]);
    end

endmodule

bind phased_dimmer pd_checker #(.NUM_STR(NUM_STR), .POS_W(POS_W)) u_chk (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .gsc_tick(gsc_tick),
    .str_out(str_out), .act_byp(act_byp), .pos(pos), .flen(flen), .act_w(act_w)
);

// File: tb/phased_dimmer_bench.sv
module phased_dimmer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;
    localparam int FRAME_TICKS = 40;

    typedef struct packed {
        logic [1:0]  mode;
        logic [11:0] gain;
        logic [11:0] on0;
        logic [3:0]  on_step;
        logic [11:0] d0;
        logic [3:0]  d_step;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 12'd2048, 12'd10,   4'd2, 12'd0,    4'd2},  // leading, halved gain
        '{2'd1, 12'd2048, 12'd4,    4'd3, 12'd20,   4'd1},  // centre
        '{2'd2, 12'd4095, 12'd10,   4'd1, 12'd5,    4'd1},  // trailing fwd, wraps
        '{2'd3, 12'd3000, 12'd20,   4'd1, 12'd0,    4'd2},  // trailing back
        '{2'd0, 12'd0,    12'd4095, 4'd0, 12'd3,    4'd0},  // zero gain
        '{2'd0, 12'd4095, 12'd4095, 4'd0, 12'd0,    4'd0},  // full width
        '{2'd0, 12'd4095, 12'd100,  4'd0, 12'd4095, 4'd0},  // max delay lead
        '{2'd2, 12'd4095, 12'd4095, 4'd0, 12'd10,   4'd0},  // full width wrap
        '{2'd1, 12'd4095, 12'd20,   4'd2, 12'd0,    4'd0},  // centre clipped at 0
        '{2'd3, 12'd4095, 12'd10,   4'd1, 12'd4095, 4'd0}   // max delay back
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic        gsc_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        pwm_in = 1'b0;
    logic [NS-1:0] str_out;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    int s_on [NS], s_dly [NS], s_gain, s_mode, s_byp;
    int a_on [NS], a_dly [NS], a_gain, a_mode, a_byp;
    int m_len = 0, m_ticks = 0;
    bit m_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phased_dimmer u_phased_dimmer (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .gsc_tick(gsc_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_in(pwm_in), .str_out(str_out)
    );

    function automatic bit model_on(int mode, int w, int d, int l, int p);
        int rise, fall;
        if (p >= l || w == 0) return 1'b0;
        case (mode)
            0: begin rise = d; fall = d + w; end
            1: begin rise = d - w / 2; fall = rise + w; end
            2: begin
                fall = d; rise = d - w;
                if (rise < 0) return (p < fall) || (p >= l + rise);
            end
            default: begin fall = l - d; rise = fall - w; end
        endcase
        return (p >= rise) && (p < fall);
    endfunction

    function automatic string mode_tag(int mode);
        case (mode)
            0: return "R6 leading";
            1: return "R7 centre";
            2: return "R8 trailing-fwd";
            default: return "R9 trailing-back";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(addr); wr_data = 12'(data);
        @(negedge clk);
        wr_en = 1'b0;
        // R2 address map in the model
        if (addr < 16)       s_on[addr] = data;
        else if (addr < 32)  s_dly[addr-16] = data;
        else if (addr == 32) s_gain = data;
        else if (addr == 33) s_mode = data & 3;
        else if (addr == 34) s_byp = data & 1;
    endtask

    task automatic strobe();
        @(negedge clk); frame_stb = 1'b1;
        @(negedge clk); frame_stb = 1'b0;
        for (int i = 0; i < NS; i++) begin a_on[i] = s_on[i]; a_dly[i] = s_dly[i]; end
        a_gain = s_gain; a_mode = s_mode; a_byp = s_byp;
        if (m_seen) m_len = m_ticks;
        m_seen = 1; m_ticks = 0;
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk); gsc_tick = 1'b1;
        @(negedge clk); gsc_tick = 1'b0;
        m_ticks++;
        @(negedge clk);
    endtask

    // one frame of FRAME_TICKS ticks; checks each position 0..FRAME_TICKS
    task automatic run_frame(input bit chk, input int mid_p, input string tag_in);
        int   bad_p [NS];
        int   bad_a [NS];
        int   bad_e [NS];
        string tag;
        for (int i = 0; i < NS; i++) bad_p[i] = -1;
        strobe();
        for (int p = 0; p <= FRAME_TICKS; p++) begin
            if (p > 0) tick();
            if (p == mid_p) wr(0, 0);
            for (int i = 0; i < NS; i++) begin
                int w;
                bit e;
                w = (a_on[i] * a_gain) / 4096;
                e = model_on(a_mode, w, a_dly[i], m_len, p);
                if (str_out[i] !== e && bad_p[i] < 0) begin
                    bad_p[i] = p; bad_a[i] = int'(str_out[i]); bad_e[i] = int'(e);
                end
            end
        end
        if (chk) begin
            tag = (tag_in == "") ? mode_tag(a_mode) : tag_in;
            for (int i = 0; i < NS; i++)
                check(bad_p[i] < 0, $sformatf("%s string %0d pos %0d", tag, i, bad_p[i]),
                      bad_a[i], bad_e[i]);
        end
    endtask

    task automatic load_vec(input vec_t v);
        wr(32, int'(v.gain));
        wr(33, int'(v.mode));
        for (int i = 0; i < NS; i++) begin
            wr(i,      (int'(v.on0) + i * int'(v.on_step)) % 4096);
            wr(16 + i, (int'(v.d0)  + i * int'(v.d_step))  % 4096);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin s_on[i] = 0; s_dly[i] = 0; a_on[i] = 0; a_dly[i] = 0; end
        s_gain = 0; s_mode = 0; s_byp = 0; a_gain = 0; a_mode = 0; a_byp = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        check(str_out == '0, "R1 reset outputs", int'(str_out), 0);

        // warm-up: two frames so that L is measured (R4)
        run_frame(1'b0, -1, "");
        run_frame(1'b1, -1, "R4 unmeasured");

        // R2: writes to unmapped addresses have no effect on later frames
        wr(35, 12'hFFF);
        wr(63, 12'hFFF);

        // table of scenarios
        for (int v = 0; v < NV; v++) begin
            load_vec(VECS[v]);
            run_frame(1'b1, -1, (VECS[v].gain == 0) ? "R5 zero width" : "");
        end

        // R3: mid-frame write only reaches the shadow set
        load_vec(VECS[0]);
        run_frame(1'b1, 5, "R3 old set held");
        run_frame(1'b1, -1, "R3 new set at strobe");

        // R10 / R11: bypass with staggered lanes
        wr(34, 1);
        strobe();
        begin
            int first [NS];
            logic [NS-1:0] prev;
            for (int i = 0; i < NS; i++) first[i] = -1;
            prev = str_out;
            for (int c = 0; c < 448; c++) begin
                @(negedge clk);
                for (int i = 0; i < NS; i++)
                    if (c >= 320 && str_out[i] && !prev[i] && first[i] < 0) first[i] = c;
                prev = str_out;
                pwm_in = ((c % 64) < 20);
            end
            pwm_in = 1'b0;
            check(first[0] >= 0, "R11 bypass lane 0 active", first[0], 320);
            for (int i = 1; i < NS; i++)
                check(first[i] >= 0 && first[0] >= 0 && first[i] - first[0] == 4 * i,
                      $sformatf("R10 stagger string %0d", i), first[i] - first[0], 4 * i);
        end
        repeat (80) @(negedge clk);

        // R11: clearing bypass returns generated waveforms
        wr(34, 0);
        run_frame(1'b0, -1, "");
        run_frame(1'b1, -1, "R11 generated again");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule